// File: doc/BRIEF.md
# Flash Array Programming Sequencer

This block is the host-side controller for a byte-wide parallel flash programming port. A start pulse latches a byte count, a completion-detection mode and a verify enable. The block then clears the whole array with one long erase strobe. After that it takes image bytes one at a time from a valid/ready stream and writes each byte to the next address, beginning at zero. For every byte it first presents the address, then the data, then the program mode, and only then pulses the active-low strobe.

The block does not wait a fixed time after each strobe. It finds the end of the write cycle in one of two ways. In ready/busy mode it watches a busy line that the flash pulls low and later releases. In polling mode it reads the written location back and waits until bit 7 stops showing the complement of the written bit. A timeout catches a flash that never completes.

When verify is enabled, the host sends the same image a second time. The block reads each address back and compares it with that byte. A mismatch stops the run and reports the address. Done and error flags stay set until the next start.

Top module: `flash_seq`

## Requirements
- R1: While reset is low, the strobe is high, the flash mode is 0 (idle), the data output enable, stream ready, done and error are all low.
- R2: After an accepted start, the first flash activity is a single erase: mode 1 with the strobe held low for exactly ERASE_CYC clock cycles. Afterwards every address that was not programmed reads 0xFF.
- R3: Each byte goes through four stages, one clock cycle each for the first three: the address alone with mode 0 and output enable low; then the data with output enable high; then mode 2 (program); then the strobe goes low. The address and data hold steady until the strobe returns high.
- R4: Every program strobe pulse is low for exactly STROBE_W cycles. A setting below one is treated as one.
- R5: Bytes are accepted only while ready is high, exactly byte-count of them per pass. They are written to addresses 0, 1, 2, … in order, with one program pulse per byte.
- R6: In ready/busy mode (poll select 0), a write is complete when the busy input returns high after it has been seen low during the pulse or the wait. No new byte is requested while the flash is busy.
- R7: In polling mode (poll select 1), the block drives mode 3 (read) with output enable low at the written address. The write is complete when read bit 7 equals the written bit 7.
- R8: If a write shows no completion within TIMEOUT_CYC wait cycles, the error flag rises and the failing address is reported. The sequence then stops, with the strobe high and ready low.
- R9: With verify enabled, after the last write the block takes the image a second time, reads each address in mode 3, and raises done only if every byte matches.
- R10: A verify mismatch raises the error flag, reports the mismatching address and stops without requesting further bytes.
- R11: Done and error are never high together. Each holds until the next start. A start while a run is in progress is ignored.
- R12: A byte count of zero performs the erase and then raises done without requesting any bytes or issuing any program pulse, even with verify enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; sampled only when no run is in progress |
| poll_mode_i | input | 1 | Completion detection: 0 ready/busy, 1 bit-7 polling |
| verify_en_i | input | 1 | Enable the read-back verify pass |
| byte_cnt_i | input | AW+1 | Number of image bytes to write |
| s_valid_i | input | 1 | Image byte valid |
| s_data_i | input | 8 | Image byte |
| s_ready_o | output | 1 | Block accepts an image byte this cycle |
| fl_addr_o | output | AW | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_wdata_oe_o | output | 1 | Write data output enable |
| fl_rdata_i | input | 8 | Flash read data |
| fl_mode_o | output | 2 | Control mode: 0 idle, 1 erase, 2 program, 3 read |
| fl_strobe_n_o | output | 1 | Active-low program/erase strobe |
| fl_rdy_i | input | 1 | Flash ready (high) / busy (low) |
| done_o | output | 1 | Run finished successfully |
| err_o | output | 1 | Run stopped on a timeout or verify mismatch |
| fail_addr_o | output | AW | Address of the failure |

## Verification
Timing is counted from the clock edge on which start is sampled. The erase strobe is low from the following cycle for ERASE_CYC cycles, and there is one recovery cycle after it. An accepted byte then takes three setup cycles before its STROBE_W-cycle pulse. In the wait phase, completion moves the block to its next state on the following edge. A timeout raises the error flag TIMEOUT_CYC cycles after the wait began. A verify read is compared two cycles after its byte is accepted. The bench samples every output and drives every input at the falling edge, so each value it sees has been stable for half a period. Its bus monitor measures pulse lengths and the setup order in whole cycles against these counts. The final flags and array contents are checked only after done or error has been seen.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    FM_IDLE  = 2'd0,
    FM_ERASE = 2'd1,
    FM_PROG  = 2'd2,
    FM_READ  = 2'd3
  } fmode_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ERASE, S_ER_REC, S_FETCH, S_SET_A, S_SET_D, S_SET_M,
    S_PULSE, S_WAIT, S_V_FETCH, S_V_READ, S_V_CMP, S_DONE, S_ERR
  } seq_st_t;

  // true in the final cycle of a window of len cycles, cnt counting from 0
  function automatic logic f_last_tick(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  // polled write finished: bit 7 no longer complemented
  function automatic logic f_poll_ok(input logic [7:0] rd, input logic [7:0] wr);
    return rd[7] == wr[7];
  endfunction

  function automatic logic f_match(input logic [7:0] rd, input logic [7:0] expv);
    return rd == expv;
  endfunction

endpackage

// File: rtl/flash_seq_cnt.sv
module flash_seq_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= q + 1'b1;
  end
endmodule

// File: rtl/flash_seq_cmpl.sv
module flash_seq_cmpl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,     // before the pulse: forget any earlier busy
  input  logic track_i,   // pulse or wait: record a low busy line
  input  logic watch_i,   // wait phase: completion may be reported
  input  logic poll_i,
  input  logic rdy_i,
  input  logic poll_hit_i,
  output logic done_o
);
  logic seen_busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen_busy_q <= 1'b0;
    else if (clr_i)             seen_busy_q <= 1'b0;
    else if (track_i && !rdy_i) seen_busy_q <= 1'b1;
  end

  assign done_o = watch_i && (poll_i ? poll_hit_i : (seen_busy_q && rdy_i));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW          = 8,
  parameter int STROBE_W    = 2,
  parameter int ERASE_CYC   = 40,
  parameter int TIMEOUT_CYC = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          poll_mode_i,
  input  logic          verify_en_i,
  input  logic [AW:0]   byte_cnt_i,
  input  logic          s_valid_i,
  input  logic [7:0]    s_data_i,
  output logic          s_ready_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_wdata_o,
  output logic          fl_wdata_oe_o,
  input  logic [7:0]    fl_rdata_i,
  output logic [1:0]    fl_mode_o,
  output logic          fl_strobe_n_o,
  input  logic          fl_rdy_i,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] fail_addr_o
);
  localparam int STROBE_LEN = (STROBE_W < 1) ? 1 : STROBE_W;
  localparam int PMAX       = (ERASE_CYC > STROBE_LEN) ? ERASE_CYC : STROBE_LEN;
  localparam int PW         = $clog2(PMAX + 1);
  localparam int TW         = $clog2(TIMEOUT_CYC + 1);

  seq_st_t       st_q;
  logic [AW:0]   addr_q, cnt_q, addr_nxt;
  logic [7:0]    data_q;
  logic          poll_q, vfy_q;
  logic [AW-1:0] fail_q;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tcnt;
  fmode_t        mode_w;

  // named internal events
  logic idle_like, erase_last, pulse_last, wr_complete, tmo_hit, vfy_bad, last_byte, poll_hit;

  assign idle_like  = (st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_ERR);
  assign addr_nxt   = addr_q + 1'b1;
  assign last_byte  = (addr_nxt == cnt_q);
  assign erase_last = (st_q == S_ERASE) && f_last_tick(32'(pcnt), ERASE_CYC);
  assign pulse_last = (st_q == S_PULSE) && f_last_tick(32'(pcnt), STROBE_LEN);
  assign tmo_hit    = (st_q == S_WAIT)  && f_last_tick(32'(tcnt), TIMEOUT_CYC);
  assign poll_hit   = f_poll_ok(fl_rdata_i, data_q);
  assign vfy_bad    = (st_q == S_V_CMP) && !f_match(fl_rdata_i, data_q);

  flash_seq_cnt #(.W(PW)) u_pulse_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(!(st_q == S_ERASE || st_q == S_PULSE)),
    .en(st_q == S_ERASE || st_q == S_PULSE),
    .q(pcnt)
  );

  flash_seq_cnt #(.W(TW)) u_tmo_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(st_q != S_WAIT),
    .en(st_q == S_WAIT),
    .q(tcnt)
  );

  flash_seq_cmpl u_cmpl (
    .clk(clk), .rst_n(rst_n),
    .clr_i(st_q == S_SET_M),
    .track_i(st_q == S_PULSE || st_q == S_WAIT),
    .watch_i(st_q == S_WAIT),
    .poll_i(poll_q),
    .rdy_i(fl_rdy_i),
    .poll_hit_i(poll_hit),
    .done_o(wr_complete)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      poll_q <= 1'b0;
      vfy_q  <= 1'b0;
      fail_q <= '0;
    end else begin
      case (st_q)
        S_IDLE, S_DONE, S_ERR: begin
          if (start_i) begin
            st_q   <= S_ERASE;
            addr_q <= '0;
            cnt_q  <= byte_cnt_i;
            poll_q <= poll_mode_i;
            vfy_q  <= verify_en_i;
          end
        end
        S_ERASE:  if (erase_last) st_q <= S_ER_REC;
        S_ER_REC: st_q <= (cnt_q == '0) ? S_DONE : S_FETCH;
        S_FETCH: begin
          if (s_valid_i) begin
            data_q <= s_data_i;
            st_q   <= S_SET_A;
          end
        end
        S_SET_A: st_q <= S_SET_D;
        S_SET_D: st_q <= S_SET_M;
        S_SET_M: st_q <= S_PULSE;
        S_PULSE: if (pulse_last) st_q <= S_WAIT;
        S_WAIT: begin
          if (wr_complete) begin
            if (!last_byte) begin
              addr_q <= addr_nxt;
              st_q   <= S_FETCH;
            end else if (vfy_q) begin
              addr_q <= '0;
              st_q   <= S_V_FETCH;
            end else begin
              st_q   <= S_DONE;
            end
          end else if (tmo_hit) begin
            fail_q <= addr_q[AW-1:0];
            st_q   <= S_ERR;
          end
        end
        S_V_FETCH: begin
          if (s_valid_i) begin
            data_q <= s_data_i;
            st_q   <= S_V_READ;
          end
        end
        S_V_READ: st_q <= S_V_CMP;
        S_V_CMP: begin
          if (vfy_bad) begin
            fail_q <= addr_q[AW-1:0];
            st_q   <= S_ERR;
          end else if (last_byte) begin
            st_q   <= S_DONE;
          end else begin
            addr_q <= addr_nxt;
            st_q   <= S_V_FETCH;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      S_ERASE, S_ER_REC:          mode_w = FM_ERASE;
      S_SET_M, S_PULSE:           mode_w = FM_PROG;
      S_WAIT:                     mode_w = poll_q ? FM_READ : FM_PROG;
      S_V_READ, S_V_CMP:          mode_w = FM_READ;
      default:                    mode_w = FM_IDLE;
    endcase
  end

  assign fl_mode_o     = mode_w;
  assign fl_addr_o     = addr_q[AW-1:0];
  assign fl_wdata_o    = data_q;
  assign fl_wdata_oe_o = (st_q == S_SET_D) || (st_q == S_SET_M) || (st_q == S_PULSE) ||
                         ((st_q == S_WAIT) && !poll_q);
  assign fl_strobe_n_o = !((st_q == S_ERASE) || (st_q == S_PULSE));
  assign s_ready_o     = (st_q == S_FETCH) || (st_q == S_V_FETCH);
  assign done_o        = (st_q == S_DONE);
  assign err_o         = (st_q == S_ERR);
  assign fail_addr_o   = fail_q;

  logic unused_idle;
  assign unused_idle = idle_like;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int AW       = 8,
  parameter int STROBE_W = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          fl_strobe_n_o,
  input logic [1:0]    fl_mode_o,
  input logic          fl_wdata_oe_o,
  input logic [AW-1:0] fl_addr_o,
  input logic [7:0]    fl_wdata_o,
  input logic          s_ready_o,
  input logic          done_o,
  input logic          err_o,
  input logic          wr_complete,
  input logic          tmo_hit
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (!fl_strobe_n_o && fl_mode_o == 2'd2) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  // R3
  strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_strobe_n_o |-> (fl_mode_o == 2'd1 || fl_mode_o == 2'd2));

  // R3
  oe_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_strobe_n_o && fl_mode_o == 2'd2) |-> fl_wdata_oe_o);

  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_strobe_n_o && !$past(fl_strobe_n_o)) |-> ($stable(fl_addr_o) && $stable(fl_wdata_o)));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_strobe_n_o && low_run != 16'd0) |-> (low_run == 16'(STROBE_W)));

  // R6
  no_prog_after_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_complete |=> (fl_mode_o != 2'd2));

  // R8
  tmo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !wr_complete) |=> err_o);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (fl_strobe_n_o && !s_ready_o));

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
endmodule

bind flash_seq flash_seq_chk #(.AW(AW), .STROBE_W(STROBE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .fl_strobe_n_o(fl_strobe_n_o), .fl_mode_o(fl_mode_o),
  .fl_wdata_oe_o(fl_wdata_oe_o), .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o),
  .s_ready_o(s_ready_o), .done_o(done_o), .err_o(err_o),
  .wr_complete(wr_complete), .tmo_hit(tmo_hit)
);

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
  localparam int AW = 8, SW = 2, EC = 40, TC = 48;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, poll = 1'b0, vfy = 1'b0;
  logic [AW:0] cnt = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, oe, strobe_n, rdy, done, err;
  logic [AW-1:0] addr, fail_addr;
  logic [7:0] wdata, rdata;
  logic [1:0] mode;

  flash_seq #(.AW(AW), .STROBE_W(SW), .ERASE_CYC(EC), .TIMEOUT_CYC(TC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .poll_mode_i(poll), .verify_en_i(vfy),
    .byte_cnt_i(cnt), .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .fl_addr_o(addr), .fl_wdata_o(wdata), .fl_wdata_oe_o(oe), .fl_rdata_i(rdata),
    .fl_mode_o(mode), .fl_strobe_n_o(strobe_n), .fl_rdy_i(rdy),
    .done_o(done), .err_o(err), .fail_addr_o(fail_addr)
  );

  // ---------------- flash model ----------------
  logic [7:0] mem [DEPTH];
  logic [7:0] img [DEPTH];
  logic busy = 1'b0;
  int wcnt = 0, ecnt = 0, lat = 4, nprog = 0, scr_seq = 0, scr_seen = 0;
  logic [AW-1:0] wa = '0;
  logic [7:0] wd = '0;
  logic stuck_en = 1'b0, bad_en = 1'b0;
  logic [AW-1:0] stuck_addr = '0, bad_addr = '0;

  always @(posedge clk) begin
    if (scr_seq != scr_seen) begin
      scr_seen <= scr_seq;
      busy <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 13) ^ 8'h5A;
    end else begin
      if (mode == 2'd1 && !strobe_n) ecnt <= ecnt + 1;
      else if (ecnt != 0) begin
        if (ecnt >= EC) for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        ecnt <= 0;
      end
      if (!busy && mode == 2'd2 && !strobe_n) begin
        busy <= 1'b1; wcnt <= lat; wa <= addr; wd <= wdata; nprog <= nprog + 1;
      end else if (busy && !(stuck_en && wa == stuck_addr)) begin
        if (wcnt <= 1) begin mem[wa] <= mem[wa] & wd; busy <= 1'b0; end
        else wcnt <= wcnt - 1;
      end
    end
  end

  assign rdy   = !busy;
  assign rdata = (busy && addr == wa) ? {~wd[7], 7'h2A} :
                 (bad_en && addr == bad_addr) ? (mem[addr] ^ 8'h01) : mem[addr];

  // ---------------- bus monitor (falling edge) ----------------
  int lowlen = 0, pulse_bad = 0, erase_runs = 0, erase_bad = 0, order_bad = 0;
  int oe_read_bad = 0, consumed = 0, rb_bad = 0;
  logic [1:0] lowmode = '0, h1m = '0, h2m = '0;
  logic h1o = 1'b0, h2o = 1'b0, h3o = 1'b0, prev_sn = 1'b1;
  logic [AW-1:0] h1a = '0, h2a = '0, h3a = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!strobe_n) begin lowlen++; lowmode = mode; end
      else if (lowlen != 0) begin
        if (lowmode == 2'd2 && lowlen != SW) pulse_bad++;
        if (lowmode == 2'd1) begin erase_runs++; if (lowlen != EC) erase_bad++; end
        lowlen = 0;
      end
      if (!strobe_n && prev_sn && mode == 2'd2) begin
        if (!(h1m == 2'd2 && h1o && h2m == 2'd0 && h2o && !h3o &&
              h1a == addr && h2a == addr && h3a == addr && wdata == img[addr]))
          order_bad++;
      end
      if (mode == 2'd3 && oe) oe_read_bad++;
      if (s_ready && busy) rb_bad++;
      if (s_valid && s_ready) consumed++;
      h3o = h2o; h3a = h2a;
      h2o = h1o; h2a = h1a; h2m = h1m;
      h1o = oe;  h1a = addr; h1m = mode;
      prev_sn = strobe_n;
    end
  end

  // ---------------- bookkeeping ----------------
  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic make_img(input int seed);
    for (int i = 0; i < DEPTH; i++) img[i] = 8'(i * 29 + seed * 7) ^ 8'(i >> 1);
  endtask

  task automatic scramble();
    @(negedge clk); scr_seq++;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_start(input bit p, input bit v, input int c);
    @(negedge clk);
    poll = p; vfy = v; cnt = (AW+1)'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int count, input int passes, input int gap);
    for (int p = 0; p < passes; p++) begin
      for (int i = 0; i < count; i++) begin
        repeat (gap) @(negedge clk);
        if (err || done) begin s_valid = 1'b0; return; end
        s_valid = 1'b1; s_data = img[i];
        while (!s_ready && !err && !done) @(negedge clk);
        if (err || done) begin s_valid = 1'b0; return; end
        @(negedge clk);
        s_valid = 1'b0;
      end
    end
  endtask

  task automatic wait_end(input int limit);
    int n = 0;
    while (!done && !err && n < limit) begin @(negedge clk); n++; end
    if (n >= limit) chk(1'b0, "R11", "run did not finish (watchdog)", n, limit);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    #5;
    chk(strobe_n == 1'b1, "R1", "strobe in reset", int'(strobe_n), 1);
    chk(mode == 2'd0, "R1", "mode in reset", int'(mode), 0);
    chk(!oe && !s_ready, "R1", "oe/ready in reset", int'({oe, s_ready}), 0);
    chk(!done && !err, "R1", "flags in reset", int'({done, err}), 0);
  endtask

  task automatic t_rdy_verify();
    int e0, p0, c0, pb0, ob0, rb0, eb0;
    make_img(3); lat = 6; scramble();
    e0 = erase_runs; p0 = nprog; c0 = consumed; pb0 = pulse_bad; ob0 = order_bad; rb0 = rb_bad; eb0 = erase_bad;
    do_start(1'b0, 1'b1, 5);
    fork feed(5, 2, 0); wait_end(4000); join
    chk(done && !err, "R9", "verify pass done", int'({done, err}), 2);
    chk(erase_runs - e0 == 1 && erase_bad == eb0, "R2", "single erase of ERASE_CYC", erase_runs - e0, 1);
    chk(nprog - p0 == 5, "R5", "program pulses", nprog - p0, 5);
    chk(consumed - c0 == 10, "R9", "bytes taken over two passes", consumed - c0, 10);
    chk(pulse_bad == pb0, "R4", "strobe width errors", pulse_bad - pb0, 0);
    chk(order_bad == ob0, "R3", "setup order errors", order_bad - ob0, 0);
    chk(rb_bad == rb0, "R6", "ready while busy", rb_bad - rb0, 0);
    for (int i = 0; i < 5; i++) chk(mem[i] == img[i], "R5", "array byte", int'(mem[i]), int'(img[i]));
    chk(mem[5] == 8'hFF, "R2", "unwritten byte erased", int'(mem[5]), 255);
  endtask

  task automatic t_poll();
    int c0, o0, ob0;
    make_img(11); lat = 9; scramble();
    c0 = consumed; o0 = oe_read_bad; ob0 = order_bad;
    do_start(1'b1, 1'b0, 7);
    fork feed(7, 1, 2); wait_end(4000); join
    chk(done && !err, "R7", "poll run done", int'({done, err}), 2);
    chk(consumed - c0 == 7, "R5", "bytes taken with gaps", consumed - c0, 7);
    chk(oe_read_bad == o0, "R7", "oe driven while reading", oe_read_bad - o0, 0);
    chk(order_bad == ob0, "R3", "setup order errors", order_bad - ob0, 0);
    for (int i = 0; i < 7; i++) chk(mem[i] == img[i], "R7", "polled byte", int'(mem[i]), int'(img[i]));
  endtask

  task automatic t_fast_rdy();
    int rb0;
    make_img(5); lat = 1; scramble(); rb0 = rb_bad;
    do_start(1'b0, 1'b0, 3);
    fork feed(3, 1, 0); wait_end(2000); join
    chk(done && !err, "R6", "one-cycle busy seen", int'({done, err}), 2);
    chk(rb_bad == rb0, "R6", "ready while busy", rb_bad - rb0, 0);
    for (int i = 0; i < 3; i++) chk(mem[i] == img[i], "R6", "fast byte", int'(mem[i]), int'(img[i]));
  endtask

  task automatic t_timeout();
    int c0, lows = 0, rdys = 0;
    make_img(7); lat = 4; scramble();
    stuck_en = 1'b1; stuck_addr = 8'd2; c0 = consumed;
    do_start(1'b0, 1'b0, 4);
    fork feed(4, 1, 0); wait_end(4000); join
    chk(err && !done, "R8", "timeout error", int'({done, err}), 1);
    chk(fail_addr == 8'd2, "R8", "timeout address", int'(fail_addr), 2);
    chk(consumed - c0 == 3, "R8", "bytes taken before stop", consumed - c0, 3);
    repeat (30) begin @(negedge clk); if (!strobe_n) lows++; if (s_ready) rdys++; end
    chk(lows == 0 && rdys == 0, "R8", "quiet after error", lows + rdys, 0);
    chk(err, "R11", "error holds", int'(err), 1);
    stuck_en = 1'b0;
  endtask

  task automatic t_vfy_bad();
    int c0;
    make_img(9); lat = 3; scramble();
    bad_en = 1'b1; bad_addr = 8'd3; c0 = consumed;
    do_start(1'b0, 1'b1, 6);
    chk(!err, "R11", "error cleared by start", int'(err), 0);
    fork feed(6, 2, 0); wait_end(4000); join
    chk(err && !done, "R10", "mismatch error", int'({done, err}), 1);
    chk(fail_addr == 8'd3, "R10", "mismatch address", int'(fail_addr), 3);
    chk(consumed - c0 == 10, "R10", "bytes taken before stop", consumed - c0, 10);
    bad_en = 1'b0;
  endtask

  task automatic t_zero();
    int e0, p0, c0;
    scramble(); e0 = erase_runs; p0 = nprog; c0 = consumed;
    do_start(1'b0, 1'b1, 0);
    wait_end(1000);
    chk(done && !err, "R12", "zero count done", int'({done, err}), 2);
    chk(erase_runs - e0 == 1, "R12", "erase still done", erase_runs - e0, 1);
    chk(nprog == p0 && consumed == c0, "R12", "no bytes or pulses", (nprog - p0) + (consumed - c0), 0);
    chk(mem[0] == 8'hFF, "R2", "erased byte", int'(mem[0]), 255);
  endtask

  task automatic t_restart();
    int e0, p0, c0, held = 0;
    make_img(13); lat = 5; scramble();
    e0 = erase_runs; p0 = nprog; c0 = consumed;
    do_start(1'b0, 1'b0, 8);
    fork
      feed(8, 1, 0);
      begin
        repeat (100) @(negedge clk);
        cnt = 1; start = 1'b1; @(negedge clk); start = 1'b0;
      end
      wait_end(4000);
    join
    chk(done && !err, "R11", "run survives mid start", int'({done, err}), 2);
    chk(erase_runs - e0 == 1, "R11", "no second erase", erase_runs - e0, 1);
    chk(nprog - p0 == 8 && consumed - c0 == 8, "R11", "full byte count kept", nprog - p0, 8);
    repeat (20) begin @(negedge clk); if (done) held++; end
    chk(held == 20, "R11", "done holds", held, 20);
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL R11 watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    make_img(0);
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_rdy_verify();
    t_poll();
    t_fast_rdy();
    t_timeout();
    t_vfy_bad();
    t_zero();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule